// File: doc/BRIEF.md
# NOR Flash Command Interpreter

This block decodes the bus write cycles that a host issues to a parallel NOR flash and tracks the operating mode of the device. Each qualified write strobe carries an address and a data byte. The block matches these against unlock pairs and command bytes. It starts the external program and erase engines with single-cycle pulses and follows their done and timeout inputs. It also tells the read datapath what a read should return: array contents, operation status or identification codes.

A sequence begins with two unlock writes, AA at 0x555 and then 55 at 0x2AA. A command byte written to 0x555 follows. A0 selects program, and the next write supplies the target address and data. 90 enters identification mode. 80 starts an erase setup, which needs a second unlock pair and then 30 at any address inside the sector to erase, or 10 at 0x555 to erase the whole chip. During an erase, B0 suspends it and 30 resumes it. F0 is the abort word. Only the low 11 address bits take part in the unlock and command-address comparisons. The sector number is taken from the top SECT_W bits of the address.

The "base mode" is erase-suspend while an erase is held suspended, and read-array otherwise. The suspended state survives an aborted or mistyped sequence and a program run from suspend.

Top module: `nor_cmd_interp`

## Requirements
- R1: After reset the mode output is read-array (0), read select is array (0), and no start, suspend or resume pulse is driven.
- R2: A write inside a sequence that does not match the expected unlock address/data or command returns the machine to base mode. An erase setup (80) attempted while suspended also falls back to base mode.
- R3: An F0 write at any step of an unlock, program or erase sequence returns to base mode, whatever its address.
- R4: After AA@0x555, 55@0x2AA and A0@0x555, the next write is latched on pgmAddr/pgmData. pgmStart pulses for exactly one cycle, in the cycle after that write, and the mode becomes program-busy (2). pgmStart and ersStart never coincide.
- R5: After 80@0x555 and a second unlock pair, 30 at any address starts a sector erase with ersSector equal to the top address bits and ersChip low. 10@0x555 starts a chip erase with ersChip high. ersStart pulses for one cycle and the mode becomes erase-busy (3). When ersDone arrives, the machine goes to read-array.
- R6: F0 writes are ignored while program or erase is busy. When pgmDone arrives, the machine goes to base mode.
- R7: 90 after the unlock pair enters identification mode (1). There, read select is ID (2) for every read sector, and every write other than F0 has no effect. F0 returns to base mode, which is suspend when identification was entered from suspend.
- R8: A timeoutErr while program or erase is busy enters error mode (5), with read select status. Only F0 leaves error mode. It goes to read-array and drops any suspended erase.
- R9: B0 during erase-busy gives one ersSuspend pulse and enters suspend mode (4). There, reads of the latched sector, or of any sector after a chip erase, select status (1), and other reads select array (0). A 30 write in suspend gives one ersResume pulse and returns to erase-busy.
- R10: A program started from suspend returns to suspend mode when pgmDone arrives.
- R11: While program or erase is busy, read select is status (1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStb | input | 1 | One-cycle qualified write strobe |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | DATA_W | Write data; commands use bits 7:0 |
| rdSect | input | SECT_W | Sector bits of the current read address |
| pgmDone | input | 1 | Program engine finished |
| ersDone | input | 1 | Erase engine finished |
| timeoutErr | input | 1 | Engine exceeded its time limit |
| pgmStart | output | 1 | One-cycle program start pulse |
| pgmAddr | output | ADDR_W | Latched program address |
| pgmData | output | DATA_W | Latched program data |
| ersStart | output | 1 | One-cycle erase start pulse |
| ersChip | output | 1 | Erase targets the whole chip |
| ersSector | output | SECT_W | Latched erase sector |
| ersSuspend | output | 1 | One-cycle suspend request to the erase engine |
| ersResume | output | 1 | One-cycle resume request to the erase engine |
| rdSel | output | 2 | Read source: 0 array, 1 status, 2 ID |
| mode | output | 3 | 0 read, 1 ID, 2 program, 3 erase, 4 suspended, 5 error |

## Verification
The properties assume that the engines raise pgmDone, ersDone and timeoutErr only while their operation runs. They also assume that a write never shares a cycle with a done or timeout, since those take priority and would hide the write. The stimulus sends directed sequences with idle cycles between writes and pulses. A long random phase follows, in which every input, including the engine responses, is randomized. A behavioural reference model in the bench tracks the expected mode, read select and pulses for both phases.

// File: rtl/nci_pkg.sv
package nci_pkg;

  typedef enum logic [3:0] {
    S_READ, S_UL1, S_UL2, S_PGM_DATA, S_PGM_BUSY,
    S_ERS_UL0, S_ERS_UL1, S_ERS_CMD, S_ERS_BUSY,
    S_SUSP, S_AUTO, S_ERR
  } state_t;

  typedef enum logic [2:0] {
    M_READ = 3'd0, M_AUTO = 3'd1, M_PGM = 3'd2,
    M_ERS  = 3'd3, M_SUSP = 3'd4, M_ERR = 3'd5
  } mode_t;

  typedef enum logic [1:0] {
    RS_ARRAY = 2'd0, RS_STATUS = 2'd1, RS_ID = 2'd2
  } rdsel_t;

  // decoded view of the current write cycle, datapath -> control
  typedef struct packed {
    logic unlockA;
    logic unlockB;
    logic cmdAddr;
    logic isReset;
    logic isAuto;
    logic isPgm;
    logic isErsSetup;
    logic isSectErs;
    logic isChipErs;
    logic isSusp;
    logic isResume;
  } decode_t;

  // strobes and mode, control -> datapath
  typedef struct packed {
    logic  latchPgm;
    logic  latchSect;
    logic  latchChip;
    mode_t mode;
  } ctrl_t;

endpackage

// File: rtl/nci_dpath.sv
module nci_dpath
  import nci_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SECT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [SECT_W-1:0] rdSect,
  input  ctrl_t             ctl,
  output decode_t           dec,
  output logic [ADDR_W-1:0] pgmAddr,
  output logic [DATA_W-1:0] pgmData,
  output logic [SECT_W-1:0] ersSector,
  output logic              ersChip,
  output logic [1:0]        rdSel
);

  localparam int UL_W = 11;
  localparam logic [UL_W-1:0] ADDR_A = 11'h555;
  localparam logic [UL_W-1:0] ADDR_B = 11'h2AA;
  localparam logic [7:0] C_UNL_A = 8'hAA, C_UNL_B = 8'h55, C_AUTO = 8'h90;
  localparam logic [7:0] C_PGM = 8'hA0, C_ESET = 8'h80, C_SECT = 8'h30;
  localparam logic [7:0] C_CHIP = 8'h10, C_SUSP = 8'hB0, C_RST = 8'hF0;

  logic [7:0] cmdByte;
  logic       atA, atB;

  assign cmdByte = wrData[7:0];
  assign atA     = (wrAddr[UL_W-1:0] == ADDR_A);
  assign atB     = (wrAddr[UL_W-1:0] == ADDR_B);

  always_comb begin
    dec            = '0;
    dec.unlockA    = atA && (cmdByte == C_UNL_A);
    dec.unlockB    = atB && (cmdByte == C_UNL_B);
    dec.cmdAddr    = atA;
    dec.isReset    = (cmdByte == C_RST);
    dec.isAuto     = (cmdByte == C_AUTO);
    dec.isPgm      = (cmdByte == C_PGM);
    dec.isErsSetup = (cmdByte == C_ESET);
    dec.isSectErs  = (cmdByte == C_SECT);
    dec.isChipErs  = (cmdByte == C_CHIP);
    dec.isSusp     = (cmdByte == C_SUSP);
    dec.isResume   = (cmdByte == C_SECT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pgmAddr   <= '0;
      pgmData   <= '0;
      ersSector <= '0;
      ersChip   <= 1'b0;
    end else begin
      if (ctl.latchPgm) begin
        pgmAddr <= wrAddr;
        pgmData <= wrData;
      end
      if (ctl.latchSect) begin
        ersSector <= wrAddr[ADDR_W-1 -: SECT_W];
        ersChip   <= 1'b0;
      end else if (ctl.latchChip) begin
        ersChip   <= 1'b1;
      end
    end
  end

  logic inSuspSect;
  assign inSuspSect = ersChip || (rdSect == ersSector);

  always_comb begin
    unique case (ctl.mode)
      M_AUTO:             rdSel = RS_ID;
      M_PGM, M_ERS, M_ERR: rdSel = RS_STATUS;
      M_SUSP:             rdSel = inSuspSect ? RS_STATUS : RS_ARRAY;
      default:            rdSel = RS_ARRAY;
    endcase
  end

  // R4: program target only moves when the control asks for a latch
  p_pgm_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.latchPgm |=> $stable(pgmAddr) && $stable(pgmData));

  // R9: the suspended sector cannot change while the erase is suspended
  p_sect_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.mode == M_SUSP) |=> $stable(ersSector) && $stable(ersChip));

endmodule

// File: rtl/nci_ctrl.sv
module nci_ctrl
  import nci_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    wrStb,
  input  decode_t dec,
  input  logic    pgmDone,
  input  logic    ersDone,
  input  logic    timeoutErr,
  output ctrl_t   ctl,
  output logic    pgmStart,
  output logic    ersStart,
  output logic    ersSuspend,
  output logic    ersResume
);

  state_t state, nxt;
  logic   susp, suspNxt;
  logic   pgmStartNxt, ersStartNxt, suspPulseNxt, resPulseNxt;
  logic   latchPgm, latchSect, latchChip;
  state_t baseState;

  assign baseState = susp ? S_SUSP : S_READ;

  always_comb begin
    nxt          = state;
    suspNxt      = susp;
    pgmStartNxt  = 1'b0;
    ersStartNxt  = 1'b0;
    suspPulseNxt = 1'b0;
    resPulseNxt  = 1'b0;
    latchPgm     = 1'b0;
    latchSect    = 1'b0;
    latchChip    = 1'b0;
    unique case (state)
      S_READ: if (wrStb && dec.unlockA) nxt = S_UL1;
      S_SUSP: begin
        if (wrStb && dec.unlockA) nxt = S_UL1;
        else if (wrStb && dec.isResume) begin
          nxt         = S_ERS_BUSY;
          resPulseNxt = 1'b1;
        end
      end
      S_UL1: if (wrStb) nxt = dec.unlockB ? S_UL2 : baseState;
      S_UL2: if (wrStb) begin
        if (dec.cmdAddr && dec.isAuto)                 nxt = S_AUTO;
        else if (dec.cmdAddr && dec.isPgm)             nxt = S_PGM_DATA;
        else if (dec.cmdAddr && dec.isErsSetup && !susp) nxt = S_ERS_UL0;
        else                                           nxt = baseState;
      end
      S_PGM_DATA: if (wrStb) begin
        if (dec.isReset) nxt = baseState;
        else begin
          nxt         = S_PGM_BUSY;
          latchPgm    = 1'b1;
          pgmStartNxt = 1'b1;
        end
      end
      S_PGM_BUSY: begin
        if (timeoutErr)   nxt = S_ERR;
        else if (pgmDone) nxt = baseState;
      end
      S_ERS_UL0: if (wrStb) nxt = dec.unlockA ? S_ERS_UL1 : baseState;
      S_ERS_UL1: if (wrStb) nxt = dec.unlockB ? S_ERS_CMD : baseState;
      S_ERS_CMD: if (wrStb) begin
        if (dec.isSectErs) begin
          nxt         = S_ERS_BUSY;
          latchSect   = 1'b1;
          ersStartNxt = 1'b1;
        end else if (dec.cmdAddr && dec.isChipErs) begin
          nxt         = S_ERS_BUSY;
          latchChip   = 1'b1;
          ersStartNxt = 1'b1;
        end else nxt = baseState;
      end
      S_ERS_BUSY: begin
        if (timeoutErr) nxt = S_ERR;
        else if (ersDone) begin
          nxt     = S_READ;
          suspNxt = 1'b0;
        end else if (wrStb && dec.isSusp) begin
          nxt          = S_SUSP;
          suspNxt      = 1'b1;
          suspPulseNxt = 1'b1;
        end
      end
      S_AUTO: if (wrStb && dec.isReset) nxt = baseState;
      S_ERR: if (wrStb && dec.isReset) begin
        nxt     = S_READ;
        suspNxt = 1'b0;
      end
      default: nxt = S_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_READ;
      susp       <= 1'b0;
      pgmStart   <= 1'b0;
      ersStart   <= 1'b0;
      ersSuspend <= 1'b0;
      ersResume  <= 1'b0;
    end else begin
      state      <= nxt;
      susp       <= suspNxt;
      pgmStart   <= pgmStartNxt;
      ersStart   <= ersStartNxt;
      ersSuspend <= suspPulseNxt;
      ersResume  <= resPulseNxt;
    end
  end

  mode_t modeNow;
  always_comb begin
    unique case (state)
      S_AUTO:     modeNow = M_AUTO;
      S_PGM_BUSY: modeNow = M_PGM;
      S_ERS_BUSY: modeNow = M_ERS;
      S_SUSP:     modeNow = M_SUSP;
      S_ERR:      modeNow = M_ERR;
      default:    modeNow = susp ? M_SUSP : M_READ;
    endcase
  end

  always_comb begin
    ctl.latchPgm  = latchPgm;
    ctl.latchSect = latchSect;
    ctl.latchChip = latchChip;
    ctl.mode      = modeNow;
  end

  p_start_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(pgmStart && ersStart));

  p_pgm_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    pgmStart |-> (state == S_PGM_BUSY || state == S_ERR || state == baseState));

  p_busy_reset_ignored_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PGM_BUSY && wrStb && dec.isReset && !pgmDone && !timeoutErr)
      |=> state == S_PGM_BUSY);

  p_auto_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_AUTO && !(wrStb && dec.isReset)) |=> state == S_AUTO);

  p_err_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_ERR && !(wrStb && dec.isReset)) |=> state == S_ERR);

  p_susp_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    ersSuspend |-> $past(state) == S_ERS_BUSY);

  p_no_setup_in_susp_r10: assert property (@(posedge clk) disable iff (!rstN)
    susp |-> state != S_ERS_CMD);

endmodule

// File: rtl/nor_cmd_interp.sv
module nor_cmd_interp
  import nci_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int SECT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [SECT_W-1:0] rdSect,
  input  logic              pgmDone,
  input  logic              ersDone,
  input  logic              timeoutErr,
  output logic              pgmStart,
  output logic [ADDR_W-1:0] pgmAddr,
  output logic [DATA_W-1:0] pgmData,
  output logic              ersStart,
  output logic              ersChip,
  output logic [SECT_W-1:0] ersSector,
  output logic              ersSuspend,
  output logic              ersResume,
  output logic [1:0]        rdSel,
  output logic [2:0]        mode
);

  decode_t dec;
  ctrl_t   ctl;

  nci_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .wrAddr(wrAddr), .wrData(wrData), .rdSect(rdSect),
    .ctl(ctl), .dec(dec), .pgmAddr(pgmAddr), .pgmData(pgmData),
    .ersSector(ersSector), .ersChip(ersChip), .rdSel(rdSel)
  );

  nci_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .dec(dec), .pgmDone(pgmDone),
    .ersDone(ersDone), .timeoutErr(timeoutErr), .ctl(ctl), .pgmStart(pgmStart),
    .ersStart(ersStart), .ersSuspend(ersSuspend), .ersResume(ersResume)
  );

  assign mode = ctl.mode;

endmodule

// File: tb/sim_nor_cmd_interp.sv
`timescale 1ns/1ps
module sim_nor_cmd_interp;
  localparam int AW = 16, DW = 8, SW = 4;

  logic clk = 0, rstN = 0, wrStb = 0, pgmDone = 0, ersDone = 0, timeoutErr = 0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic [SW-1:0] rdSect = '0;
  logic pgmStart, ersStart, ersChip, ersSuspend, ersResume;
  logic [AW-1:0] pgmAddr;
  logic [DW-1:0] pgmData;
  logic [SW-1:0] ersSector;
  logic [1:0] rdSel;
  logic [2:0] mode;

  always #2 clk = ~clk;

  nor_cmd_interp #(.ADDR_W(AW), .DATA_W(DW), .SECT_W(SW)) u0 (.*);

  int nChecks = 0, nFails = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finishUp();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int  ph, act, mSect;          // ph: sequence step, act: 0 idle 1 id 2 pgm 3 ers 4 err
  bit  mSusp, mChip;
  bit  ePgm, eErs, eSus, eRes;
  int  ePA, ePD;

  always @(posedge clk) begin
    int a11, d;
    bit ulA, ulB, ca;
    if (!rstN) begin
      ph = 0; act = 0; mSusp = 0; mChip = 0; mSect = 0;
      ePgm = 0; eErs = 0; eSus = 0; eRes = 0; ePA = 0; ePD = 0;
    end else begin
      ePgm = 0; eErs = 0; eSus = 0; eRes = 0;
      a11 = int'(wrAddr) & 'h7FF; d = int'(wrData);
      ulA = (a11 == 'h555) && (d == 'hAA);
      ulB = (a11 == 'h2AA) && (d == 'h55);
      ca  = (a11 == 'h555);
      if (act == 2) begin
        if (timeoutErr) act = 4; else if (pgmDone) act = 0;
      end else if (act == 3) begin
        if (timeoutErr) act = 4;
        else if (ersDone) begin act = 0; mSusp = 0; end
        else if (wrStb && d == 'hB0) begin act = 0; mSusp = 1; eSus = 1; end
      end else if (act == 4) begin
        if (wrStb && d == 'hF0) begin act = 0; mSusp = 0; end
      end else if (act == 1) begin
        if (wrStb && d == 'hF0) act = 0;
      end else if (wrStb) begin
        case (ph)
          0: if (ulA) ph = 1; else if (mSusp && d == 'h30) begin act = 3; eRes = 1; end
          1: ph = ulB ? 2 : 0;
          2: begin
               ph = 0;
               if (ca && d == 'h90) act = 1;
               else if (ca && d == 'hA0) ph = 3;
               else if (ca && d == 'h80 && !mSusp) ph = 4;
             end
          3: begin
               ph = 0;
               if (d != 'hF0) begin act = 2; ePgm = 1; ePA = int'(wrAddr); ePD = d; end
             end
          4: ph = ulA ? 5 : 0;
          5: ph = ulB ? 6 : 0;
          6: begin
               ph = 0;
               if (d == 'h30) begin act = 3; eErs = 1; mSect = int'(wrAddr) >> (AW-SW); mChip = 0; end
               else if (ca && d == 'h10) begin act = 3; eErs = 1; mChip = 1; end
             end
          default: ph = 0;
        endcase
      end
    end
  end

  function automatic int expMode();
    case (act)
      1: return 1; 2: return 2; 3: return 3; 4: return 5;
      default: return mSusp ? 4 : 0;
    endcase
  endfunction

  function automatic int expSel();
    int m = expMode();
    if (m == 1) return 2;
    if (m == 2 || m == 3 || m == 5) return 1;
    if (m == 4) return (mChip || int'(rdSect) == mSect) ? 1 : 0;
    return 0;
  endfunction

  // per-cycle comparison, 1 ns after the edge
  always @(posedge clk) begin
    #1;
    if (rstN && !done) begin
      chk("R2 mode", int'(mode), expMode());
      chk("R9 rdSel", int'(rdSel), expSel());
      chk("R4 pgmStart", int'(pgmStart), int'(ePgm));
      chk("R5 ersStart", int'(ersStart), int'(eErs));
      chk("R9 ersSuspend", int'(ersSuspend), int'(eSus));
      chk("R9 ersResume", int'(ersResume), int'(eRes));
      if (ePgm) begin
        chk("R4 pgmAddr", int'(pgmAddr), ePA);
        chk("R4 pgmData", int'(pgmData), ePD);
      end
      if (eErs) begin
        chk("R5 ersChip", int'(ersChip), int'(mChip));
        if (!mChip) chk("R5 ersSector", int'(ersSector), mSect);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); wrStb = 1; wrAddr = AW'(a); wrData = DW'(d);
    @(negedge clk); wrStb = 0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  task automatic unl();
    wr('h555, 'hAA); wr('h2AA, 'h55);
  endtask

  // check at a quiet point: the edge has passed, outputs settled
  task automatic chkNow(string tag, int act_, int exp_);
    #1; chk(tag, act_, exp_);
  endtask

  initial begin
    #(4 * 150000);
    nFails++;
    $display("FAIL watchdog: actual running expected finished");
    finishUp();
  end

  initial begin
    idle(3); rstN = 1; idle(1);
    chkNow("R1 reset mode", int'(mode), 0);
    chkNow("R1 reset rdSel", int'(rdSel), 0);
    chkNow("R1 reset pulses", int'({pgmStart, ersStart, ersSuspend, ersResume}), 0);

    // program, reset ignored while busy
    unl(); wr('h555, 'hA0); wr('h1234, 'h5A); idle(1);
    chkNow("R4 program busy", int'(mode), 2);
    chkNow("R11 busy status", int'(rdSel), 1);
    wr('h0, 'hF0); idle(1);
    chkNow("R6 reset ignored", int'(mode), 2);
    pulse(pgmDone); idle(1);
    chkNow("R6 done to read", int'(mode), 0);

    // wrong data and abort
    wr('h555, 'hAA); wr('h123, 'h55); idle(1);
    chkNow("R2 wrong addr", int'(mode), 0);
    wr('h555, 'hAA); wr('h7777, 'hF0);
    unl(); wr('h555, 'h90); idle(1);
    chkNow("R3 abort then auto", int'(mode), 1);
    rdSect = 4'hA; idle(1);
    chkNow("R7 id any sector", int'(rdSel), 2);
    wr('h555, 'hA0); wr('h555, 'hAA); idle(1);
    chkNow("R7 writes ignored", int'(mode), 1);
    wr('h0, 'hF0); idle(1);
    chkNow("R7 exit", int'(mode), 0);
    unl(); wr('h555, 'hA0); wr('h2222, 'hF0); idle(1);
    chkNow("R3 abort in program", int'(mode), 0);

    // sector erase, suspend, program from suspend
    unl(); wr('h555, 'h80); unl(); wr('h3456, 'h30); idle(1);
    chkNow("R5 erase busy", int'(mode), 3);
    chkNow("R5 sector", int'(ersSector), 3);
    wr('h0, 'hB0); idle(1);
    chkNow("R9 suspended", int'(mode), 4);
    rdSect = 4'h3; idle(1);
    chkNow("R9 suspended sector status", int'(rdSel), 1);
    rdSect = 4'h5; idle(1);
    chkNow("R9 other sector array", int'(rdSel), 0);
    unl(); wr('h555, 'hA0); wr('h5000, 'h11); idle(1);
    chkNow("R10 program in suspend", int'(mode), 2);
    pulse(pgmDone); idle(1);
    chkNow("R10 back to suspend", int'(mode), 4);
    unl(); wr('h555, 'h80); idle(1);
    chkNow("R2 no setup in suspend", int'(mode), 4);
    unl(); wr('h555, 'h90); wr('h0, 'hF0); idle(1);
    chkNow("R7 auto exit to suspend", int'(mode), 4);
    wr('h0, 'h30); idle(1);
    chkNow("R9 resumed", int'(mode), 3);
    pulse(timeoutErr); idle(1);
    chkNow("R8 error", int'(mode), 5);
    wr('h555, 'hAA); idle(1);
    chkNow("R8 error holds", int'(mode), 5);
    wr('h0, 'hF0); idle(1);
    chkNow("R8 error exit", int'(mode), 0);

    // chip erase
    unl(); wr('h555, 'h80); unl(); wr('h555, 'h10); idle(1);
    chkNow("R5 chip flag", int'(ersChip), 1);
    wr('h0, 'hB0); rdSect = 4'hE; idle(1);
    chkNow("R9 chip suspend status", int'(rdSel), 1);
    wr('h0, 'h30); pulse(ersDone); idle(1);
    chkNow("R5 erase done", int'(mode), 0);

    // error from program in suspend clears suspend
    unl(); wr('h555, 'h80); unl(); wr('h1000, 'h30); wr('h0, 'hB0);
    unl(); wr('h555, 'hA0); wr('h2000, 'h22); pulse(timeoutErr);
    wr('h0, 'hF0); idle(1);
    chkNow("R8 suspend dropped", int'(mode), 0);

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      @(negedge clk);
      r = int'($urandom_range(0, 99));
      wrStb = (r < 45);
      case ($urandom_range(0, 3))
        0: wrAddr = 16'h0555;
        1: wrAddr = 16'h02AA;
        2: wrAddr = 16'h0555 | AW'($urandom_range(0, 15) << 12);
        default: wrAddr = AW'($urandom);
      endcase
      case ($urandom_range(0, 9))
        0: wrData = 8'hAA; 1: wrData = 8'h55; 2: wrData = 8'h90;
        3: wrData = 8'hA0; 4: wrData = 8'h80; 5: wrData = 8'h30;
        6: wrData = 8'h10; 7: wrData = 8'hB0; 8: wrData = 8'hF0;
        default: wrData = DW'($urandom);
      endcase
      pgmDone    = ($urandom_range(0, 99) < 8);
      ersDone    = ($urandom_range(0, 99) < 4);
      timeoutErr = ($urandom_range(0, 99) < 2);
      rdSect     = SW'($urandom);
    end
    @(negedge clk); wrStb = 0; pgmDone = 0; ersDone = 0; timeoutErr = 0;
    idle(2);
    finishUp();
  end

endmodule